// File: doc/BRIEF.md
# Eight-Line Nested Priority Interrupt Controller

This block collects eight interrupt request lines and decides which one to present to a processor on a single interrupt output. It holds a pending-request set, an in-service set and a mask. When the processor pulses acknowledge, the block returns a vector one cycle later. The vector is a software-chosen 5-bit base joined to the 3-bit number of the winning line. A serviced line stays in service until software retires it with an end-of-interrupt command, unless automatic end-of-interrupt mode is on. While a line is in service, requests of lower priority wait and requests of higher priority nest on top of it.

Software reaches the block through a small register-write port and a combinational read port. Through these it can set the mask, the per-line trigger kind, the mode bits and the vector base, issue end-of-interrupt commands, and read back the request and in-service sets. A rotating mode moves the line that was just completed to the bottom of the priority order, which spreads service more evenly across the lines. An acknowledge that arrives when no eligible request remains yields the line-7 vector and sets no in-service bit. A handler can recognise such a spurious event by reading back the in-service set.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, int_out is 0 and the request, in-service, mask and trigger-select registers all read 0. All lines are edge-triggered, automatic end-of-interrupt and rotation are off, the vector base is 0, and line 0 has the highest priority and line 7 the lowest.
- R2: With rotation off, when several unmasked requests are pending and nothing is in service, acknowledge serves the lowest-numbered line first.
- R3: A line whose bit is 1 in the mask register (wr_addr 1) never raises int_out, although its request stays visible on read-back.
- R4: While a line is in service, a pending request of lower or equal priority keeps int_out at 0 until that in-service bit is cleared.
- R5: A request of higher priority than every in-service line raises int_out at once. Its acknowledge adds its bit to the in-service set, and the earlier bit stays set.
- R6: Writing wr_addr 0 with wr_data[7:6]=2'b01 (non-specific end-of-interrupt) clears the highest-priority in-service bit only.
- R7: Writing wr_addr 0 with wr_data[7:6]=2'b10 (specific end-of-interrupt) clears only the in-service bit numbered by wr_data[2:0].
- R8: With wr_addr 2 bit 0 set (automatic end-of-interrupt), an acknowledge sets no in-service bit, so a further pending request raises int_out right away.
- R9: With wr_addr 2 bit 1 set (rotation), the line whose service completes becomes the lowest priority, and the next line up becomes the highest. Any write to wr_addr 2 restores the default order.
- R10: An edge-triggered line (bit 0 in wr_addr 3) latches a request on a rising edge and keeps it after the line falls, until that line is acknowledged. A level-triggered line (bit 1) requests only while it is high.
- R11: An acknowledge while int_out is 0 returns line number 7 in the vector and leaves the in-service set unchanged.
- R12: One cycle after an acknowledge cycle, vec_vld is 1 for a single cycle and vec_out holds {base, line}, where the base is wr_addr 2 bits [7:3].
- R13: rd_data returns the request set for rd_sel 0, the in-service set for rd_sel 1, the mask for rd_sel 2 and the trigger select for rd_sel 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt to processor |
| inta | input | 1 | Acknowledge, one cycle per acknowledge |
| vec_out | output | 8 | Vector returned for the last acknowledge |
| vec_vld | output | 1 | vec_out valid pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 command, 1 mask, 2 mode/base, 3 trigger select |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read-back select |
| rd_data | output | 8 | Read-back data |

## Verification
On every cycle, the assertions check several things. Masked requests cannot drive the output. Each acknowledge produces a vector pulse. An acknowledge in automatic mode leaves the in-service set alone. A spurious acknowledge reports line 7 with no state change. A real acknowledge adds exactly one in-service bit, and a specific end-of-interrupt clears its bit. The priority order itself only shows in the bench's scenarios: which of two simultaneous lines wins, whether a request nests or waits behind the current service, and which line moves to the bottom after a rotation. The same holds for the difference between a latched edge and a dropped level.

// File: rtl/pic_pkg.sv
package pic_pkg;
  // Register addresses on the write port
  typedef enum logic [1:0] {
    REG_CMD   = 2'd0,
    REG_MASK  = 2'd1,
    REG_MODE  = 2'd2,
    REG_TRIG  = 2'd3
  } pic_reg_e;

  // Command opcodes carried in the two top bits of a REG_CMD write
  typedef enum logic [1:0] {
    OP_NOP      = 2'b00,
    OP_EOI_ANY  = 2'b01,
    OP_EOI_ONE  = 2'b10,
    OP_RSVD     = 2'b11
  } pic_op_e;
endpackage

// File: rtl/pic_capture.sv
module pic_capture #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] level_sel,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] req
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic irq_q;
    logic edge_lat;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        irq_q    <= 1'b0;
        edge_lat <= 1'b0;
      end else begin
        irq_q    <= irq_in[i];
        // a new rising edge wins over a same-cycle acknowledge clear
        edge_lat <= ((edge_lat & ~ack_clr[i]) | (irq_in[i] & ~irq_q)) & ~level_sel[i];
      end
    end
    assign req[i] = level_sel[i] ? irq_in[i] : edge_lat;
  end
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver #(
  parameter int LW = 3,
  localparam int N = 1 << LW
) (
  input  logic [N-1:0]  vec,
  input  logic [LW-1:0] low,
  output logic          found,
  output logic [LW-1:0] idx
);
  // Scan from the lowest-priority slot upward so the highest-priority hit is kept.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      logic [LW-1:0] cand;
      cand = low + LW'(k + 1);
      if (vec[cand]) begin
        found = 1'b1;
        idx   = cand;
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int LINE_W = 3,
  parameter int BASE_W = 5,
  localparam int N  = 1 << LINE_W,
  localparam int DW = BASE_W + LINE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  output logic          int_out,
  input  logic          inta,
  output logic [DW-1:0] vec_out,
  output logic          vec_vld,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  output logic [DW-1:0] rd_data
);
  // Rank 0 is the highest priority; the slot just above 'low' is rank 0.
  function automatic logic [LINE_W-1:0] rank_of(input logic [LINE_W-1:0] line,
                                                input logic [LINE_W-1:0] low);
    return line - low - LINE_W'(1);
  endfunction

  function automatic logic [N-1:0] onehot(input logic [LINE_W-1:0] line);
    return N'(1) << line;
  endfunction

  logic [N-1:0]      mask_q, level_q, isr_q;
  logic [BASE_W-1:0] base_q;
  logic              aeoi_q, rot_q;
  logic [LINE_W-1:0] low_q;

  // Named internal events
  logic [N-1:0]      irr_eff, cand, ack_clr, isr_set, eoi_clr;
  logic [LINE_W-1:0] eff_low, req_idx, isr_idx, eoi_line;
  logic              req_found, isr_found, preempt;
  logic              ack_real, ack_spur, cmd_wr, eoi_any, eoi_one;
  pic_op_e           op;

  assign eff_low = rot_q ? low_q : '1;

  pic_capture #(.N(N)) u_cap (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_sel(level_q),
    .ack_clr(ack_clr), .req(irr_eff)
  );

  assign cand = irr_eff & ~mask_q;

  pic_resolver #(.LW(LINE_W)) u_req_pick (
    .vec(cand), .low(eff_low), .found(req_found), .idx(req_idx)
  );

  pic_resolver #(.LW(LINE_W)) u_isr_pick (
    .vec(isr_q), .low(eff_low), .found(isr_found), .idx(isr_idx)
  );

  assign preempt = !isr_found || (rank_of(req_idx, eff_low) < rank_of(isr_idx, eff_low));
  assign int_out = req_found && preempt;

  assign ack_real = inta && int_out;
  assign ack_spur = inta && !int_out;
  assign ack_clr  = ack_real ? onehot(req_idx) : '0;
  assign isr_set  = (ack_real && !aeoi_q) ? onehot(req_idx) : '0;

  assign cmd_wr   = wr_en && (wr_addr == REG_CMD);
  assign op       = pic_op_e'(wr_data[DW-1 -: 2]);
  assign eoi_any  = cmd_wr && (op == OP_EOI_ANY) && isr_found;
  assign eoi_one  = cmd_wr && (op == OP_EOI_ONE);
  assign eoi_line = eoi_any ? isr_idx : wr_data[LINE_W-1:0];
  assign eoi_clr  = (eoi_any || eoi_one) ? onehot(eoi_line) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      level_q <= '0;
      isr_q   <= '0;
      base_q  <= '0;
      aeoi_q  <= 1'b0;
      rot_q   <= 1'b0;
      low_q   <= '1;
      vec_out <= '0;
      vec_vld <= 1'b0;
    end else begin
      isr_q   <= (isr_q & ~eoi_clr) | isr_set;
      vec_vld <= inta;
      if (inta) vec_out <= {base_q, ack_spur ? {LINE_W{1'b1}} : req_idx};
      if (wr_en && wr_addr == REG_MASK) mask_q  <= wr_data[N-1:0];
      if (wr_en && wr_addr == REG_TRIG) level_q <= wr_data[N-1:0];
      if (wr_en && wr_addr == REG_MODE) begin
        base_q <= wr_data[DW-1:LINE_W];
        aeoi_q <= wr_data[0];
        rot_q  <= wr_data[1];
        low_q  <= '1;
      end else if (rot_q) begin
        if (ack_real && aeoi_q)      low_q <= req_idx;
        else if (eoi_any || eoi_one) low_q <= eoi_line;
      end
    end
  end

  always_comb begin
    unique case (rd_sel)
      2'd0:    rd_data = DW'(irr_eff);
      2'd1:    rd_data = DW'(isr_q);
      2'd2:    rd_data = DW'(mask_q);
      default: rd_data = DW'(level_q);
    endcase
  end
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          inta,
  input logic          int_out,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          vec_vld,
  input logic [DW-1:0] vec_out,
  input logic          aeoi_q,
  input logic [N-1:0]  isr_q,
  input logic [N-1:0]  irr_eff,
  input logic [N-1:0]  mask_q
);
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr_eff & ~mask_q) != '0)); // R3

  AST_VEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    inta |=> vec_vld); // R12

  AST_AEOI_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && aeoi_q && !wr_en) |=> $stable(isr_q)); // R8

  AST_SPURIOUS_LINE7: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !int_out && !wr_en) |=> (vec_out[2:0] == 3'd7) && $stable(isr_q)); // R11

  AST_ACK_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && int_out && !aeoi_q && !wr_en) |=>
      ($countones(isr_q) == $countones($past(isr_q)) + 1)); // R5

  AST_SPECIFIC_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && wr_data[DW-1 -: 2] == 2'b10 && !inta) |=>
      (((isr_q >> $past(wr_data[2:0])) & N'(1)) == '0)); // R7
endmodule

bind prio_irq_ctrl pic_checker #(.N(N), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .inta(inta), .int_out(int_out),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .vec_vld(vec_vld), .vec_out(vec_out), .aeoi_q(aeoi_q),
  .isr_q(isr_q), .irr_eff(irr_eff), .mask_q(mask_q)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       int_out;
  logic       inta = 1'b0;
  logic [7:0] vec_out;
  logic       vec_vld;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .int_out(int_out),
    .inta(inta), .vec_out(vec_out), .vec_vld(vec_vld),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  localparam logic [7:0] EOI_ANY = 8'h40;
  localparam logic [7:0] BASE8   = 8'h40; // base 5'h08 in bits [7:3]

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    rd_sel = s;
    #1 d = rd_data;
  endtask

  task automatic ack(input string tag, output logic [7:0] v);
    inta = 1'b1;
    tick();
    inta = 1'b0;
    chk({tag, " vec_vld"}, {7'd0, vec_vld}, 8'd1);
    v = vec_out;
  endtask

  task automatic pulse(input logic [7:0] m);
    irq_in = irq_in | m;
    tick();
    irq_in = irq_in & ~m;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 int_out", {7'd0, int_out}, 8'd0);
    rd(2'd0, d); chk("R1 irr", d, 8'h00);
    rd(2'd1, d); chk("R1 isr", d, 8'h00);
    rd(2'd2, d); chk("R1 mask", d, 8'h00);
    rd(2'd3, d); chk("R1 trig", d, 8'h00);
  endtask

  task automatic t_fixed();
    logic [7:0] v, d;
    wr(2'd2, BASE8);
    pulse(8'h28); // lines 3 and 5, edges latched then dropped
    chk("R2 int_out", {7'd0, int_out}, 8'd1);
    rd(2'd0, d); chk("R10 edge latched", d, 8'h28);
    ack("R12", v); chk("R2/R12 first vector", v, 8'h43);
    rd(2'd1, d); chk("R2 isr", d, 8'h08);
    chk("R4 lower waits", {7'd0, int_out}, 8'd0);
    wr(2'd0, EOI_ANY);
    rd(2'd1, d); chk("R6 isr cleared", d, 8'h00);
    chk("R4 released", {7'd0, int_out}, 8'd1);
    ack("R12", v); chk("R2 second vector", v, 8'h45);
    wr(2'd0, EOI_ANY);
    rd(2'd0, d); chk("R10 edge cleared by ack", d, 8'h00);
  endtask

  task automatic t_preempt();
    logic [7:0] v, d;
    pulse(8'h40);
    ack("R5", v); chk("R5 low vector", v, 8'h46);
    pulse(8'h02);
    chk("R5 preempt int_out", {7'd0, int_out}, 8'd1);
    ack("R5", v); chk("R5 nested vector", v, 8'h41);
    rd(2'd1, d); chk("R5 both in service", d, 8'h42);
    wr(2'd0, EOI_ANY);
    rd(2'd1, d); chk("R6 highest cleared", d, 8'h40);
    wr(2'd0, 8'h86); // specific EOI, line 6
    rd(2'd1, d); chk("R7 specific cleared", d, 8'h00);
  endtask

  task automatic t_specific_only();
    logic [7:0] v, d;
    pulse(8'h80);
    ack("R7", v);
    pulse(8'h10);
    ack("R7", v);
    wr(2'd0, 8'h87); // specific EOI line 7, line 4 stays
    rd(2'd1, d); chk("R7 only named bit", d, 8'h10);
    wr(2'd0, 8'h84);
    rd(2'd1, d); chk("R7 second bit", d, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] v, d;
    wr(2'd1, 8'h04);
    rd(2'd2, d); chk("R13 mask readback", d, 8'h04);
    pulse(8'h04);
    chk("R3 masked quiet", {7'd0, int_out}, 8'd0);
    rd(2'd0, d); chk("R13 request visible", d, 8'h04);
    wr(2'd1, 8'h00);
    chk("R3 unmasked", {7'd0, int_out}, 8'd1);
    ack("R3", v); chk("R3 vector", v, 8'h42);
    wr(2'd0, EOI_ANY);
  endtask

  task automatic t_level();
    logic [7:0] v, d;
    wr(2'd3, 8'h10);
    rd(2'd3, d); chk("R13 trig readback", d, 8'h10);
    irq_in[4] = 1'b1;
    tick();
    chk("R10 level high", {7'd0, int_out}, 8'd1);
    irq_in[4] = 1'b0;
    tick();
    chk("R10 level dropped", {7'd0, int_out}, 8'd0);
    rd(2'd0, d); chk("R10 level irr", d, 8'h00);
    ack("R11", v); chk("R11 spurious vector", v, 8'h47);
    rd(2'd1, d); chk("R11 isr untouched", d, 8'h00);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_aeoi();
    logic [7:0] v, d;
    wr(2'd2, BASE8 | 8'h01);
    pulse(8'h28);
    ack("R8", v); chk("R8 vector", v, 8'h43);
    rd(2'd1, d); chk("R8 isr empty", d, 8'h00);
    chk("R8 next at once", {7'd0, int_out}, 8'd1);
    ack("R8", v); chk("R8 second vector", v, 8'h45);
    wr(2'd2, BASE8);
  endtask

  task automatic t_rotate();
    logic [7:0] v;
    wr(2'd2, BASE8 | 8'h02);
    pulse(8'h04);
    ack("R9", v);
    wr(2'd0, EOI_ANY); // line 2 now lowest, line 3 highest
    pulse(8'h0A);      // lines 1 and 3
    ack("R9", v); chk("R9 rotated winner", v, 8'h43);
    wr(2'd0, EOI_ANY);
    ack("R9", v); chk("R9 remaining line", v, 8'h41);
    wr(2'd0, EOI_ANY);
    wr(2'd2, BASE8);   // default order back
    pulse(8'h81);
    ack("R9", v); chk("R9 default restored", v, 8'h40);
    wr(2'd0, EOI_ANY);
    ack("R9", v); wr(2'd0, EOI_ANY);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_fixed();
    t_preempt();
    t_specific_only();
    t_mask();
    t_level();
    t_aeoi();
    t_rotate();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule